// File: doc/BRIEF.md
# Triggered Burst Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream, one bit per clock edge. A single high level on the enable input, seen while the block is idle, starts a burst. The burst then runs for exactly the programmed word length, whatever the enable input does afterwards. The word length can be chosen at run time, anywhere from 6 to 16 bits. A busy flag frames the burst.

The controller has two states, idle and shifting, and an iteration counter. In the idle state the shift register reloads from the parallel input on every clock, and the length select is captured on every clock as well. The word and length seen on the starting edge are the ones that get shifted out. Bits leave from the top of the selected word, and a serial input bit enters at the low end on every shift. At the end of a burst the block always spends at least one cycle idle before it can start again.

Top module: `burst_serializer`

## Requirements
- R1: While reset (`rst_ni` low, asynchronous) is asserted, `busy_o` and `ser_o` are 0, the shift register is cleared, and enable starts nothing.
- R2: When `en_i` is high on a rising clock edge while the block is idle, `busy_o` is high in the next cycle.
- R3: A burst holds `busy_o` high for exactly N consecutive cycles, where N is the captured length. This holds whether `en_i` stays high or goes low after the start.
- R4: In busy cycle k (k = 0 .. N-1), `ser_o` shows bit N-1-k of the captured word, so the word goes out most-significant bit first, one bit per cycle.
- R5: Bits of `par_i` at positions N and above have no effect on `ser_o`.
- R6: `par_i` and `len_sel_i` are sampled on the starting edge. Changes to them during a burst have no effect on that burst.
- R7: `len_sel_i` (5 bits, unsigned) sets N. Values below 6 give N = 6, values above 16 give N = 16, and all other values give N = `len_sel_i`.
- R8: If `en_i` is held high across the end of a burst, `busy_o` is low for exactly one cycle before the next burst begins.
- R9: `ser_i` is shifted in at bit 0 on every shift but never reaches `ser_o` within a burst, so it has no effect on the output.
- R10: `ser_o` is 0 whenever `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Start request, looked at only while idle |
| par_i | input | 16 | Parallel word to serialise |
| len_sel_i | input | 5 | Requested word length, clamped to 6..16 |
| ser_i | input | 1 | Bit shifted into the low end of the register |
| ser_o | output | 1 | Serial output bit, valid while busy |
| busy_o | output | 1 | High for every cycle of a burst |

## Verification
On every cycle, the checker confirms several things. It checks that an idle-time enable raises busy on the next cycle. It checks that a burst never outlasts the length captured at its start and ends on exactly that count. It also checks that the first output bit is the top bit of the captured word, and that the output stays low while idle. The bench adds further coverage through its own scenarios. These show the full bit order of each burst, the masking of upper word bits, and length clamping at both ends. They also show that mid-burst changes to enable, word, length and serial input make no difference, and that there is a one-cycle idle gap when enable is held high.

// File: rtl/bser_pkg.sv
package bser_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } state_e;

endpackage

// File: rtl/bser_len_clamp.sv
module bser_len_clamp #(
    parameter int MIN_W = 6,
    parameter int MAX_W = 16,
    parameter int SEL_W = 5
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] len_o
);

    localparam logic [SEL_W-1:0] LoLen = SEL_W'(MIN_W);
    localparam logic [SEL_W-1:0] HiLen = SEL_W'(MAX_W);

    always_comb begin
        if (sel_i < LoLen) begin
            len_o = LoLen;
        end else if (sel_i > HiLen) begin
            len_o = HiLen;
        end else begin
            len_o = sel_i;
        end
    end

endmodule

// File: rtl/bser_ctrl.sv
module bser_ctrl
    import bser_pkg::*;
#(
    parameter int MAX_W = 16,
    parameter int SEL_W = 5,
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [SEL_W-1:0] len_i,
    output logic             load_o,
    output logic             shift_o,
    output logic [SEL_W-1:0] len_o
);

    typedef struct packed {
        state_e           state;
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] len;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  last_d;

    always_comb begin
        ctrl_d = ctrl_q;
        last_d = (SEL_W'(ctrl_q.cnt) == (ctrl_q.len - SEL_W'(1)));
        unique case (ctrl_q.state)
            ST_IDLE: begin
                ctrl_d.cnt = '0;
                ctrl_d.len = len_i;
                if (en_i) begin
                    ctrl_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (last_d) begin
                    ctrl_d.state = ST_IDLE;
                    ctrl_d.cnt   = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + CNT_W'(1);
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q.state <= ST_IDLE;
            ctrl_q.cnt   <= '0;
            ctrl_q.len   <= SEL_W'(MAX_W);
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign load_o  = (ctrl_q.state == ST_IDLE);
    assign shift_o = (ctrl_q.state == ST_SHIFT);
    assign len_o   = ctrl_q.len;

endmodule

// File: rtl/bser_shreg.sv
module bser_shreg #(
    parameter int MAX_W = 16,
    parameter int SEL_W = 5,
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [MAX_W-1:0] par_i,
    input  logic             ser_i,
    input  logic [SEL_W-1:0] len_i,
    output logic             ser_o
);

    logic [MAX_W-1:0] data_d, data_q;
    logic [CNT_W-1:0] tap_d;

    always_comb begin
        data_d = data_q;
        if (load_i) begin
            data_d = par_i;
        end else if (shift_i) begin
            data_d = {data_q[MAX_W-2:0], ser_i};
        end
        tap_d = CNT_W'(len_i - SEL_W'(1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign ser_o = shift_i & data_q[tap_d];

endmodule

// File: rtl/burst_serializer.sv
module burst_serializer #(
    parameter int MIN_W = 6,
    parameter int MAX_W = 16,
    parameter int SEL_W = $clog2(MAX_W + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [MAX_W-1:0] par_i,
    input  logic [SEL_W-1:0] len_sel_i,
    input  logic             ser_i,
    output logic             ser_o,
    output logic             busy_o
);

    localparam int CNT_W = $clog2(MAX_W);

    logic [SEL_W-1:0] len_fit;
    logic [SEL_W-1:0] len_run;
    logic             load;
    logic             shift;

    bser_len_clamp #(
        .MIN_W(MIN_W),
        .MAX_W(MAX_W),
        .SEL_W(SEL_W)
    ) i_clamp (
        .sel_i(len_sel_i),
        .len_o(len_fit)
    );

    bser_ctrl #(
        .MAX_W(MAX_W),
        .SEL_W(SEL_W),
        .CNT_W(CNT_W)
    ) i_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .len_i  (len_fit),
        .load_o (load),
        .shift_o(shift),
        .len_o  (len_run)
    );

    bser_shreg #(
        .MAX_W(MAX_W),
        .SEL_W(SEL_W),
        .CNT_W(CNT_W)
    ) i_shreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .shift_i(shift),
        .par_i  (par_i),
        .ser_i  (ser_i),
        .len_i  (len_run),
        .ser_o  (ser_o)
    );

    assign busy_o = shift;

endmodule

// File: rtl/bser_checker.sv
module bser_checker #(
    parameter int MIN_W = 6,
    parameter int MAX_W = 16,
    parameter int SEL_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic [MAX_W-1:0] par_i,
    input logic [SEL_W-1:0] len_sel_i,
    input logic             ser_o,
    input logic             busy_o
);

    localparam int CNT_W = $clog2(MAX_W);

    function automatic logic [SEL_W-1:0] fit(input logic [SEL_W-1:0] s);
        if (int'(s) < MIN_W) return SEL_W'(MIN_W);
        if (int'(s) > MAX_W) return SEL_W'(MAX_W);
        return s;
    endfunction

    logic [SEL_W-1:0] run_cnt_q;
    logic [SEL_W-1:0] run_len_q;
    logic             first_bit_q;
    logic [CNT_W-1:0] top_idx;

    assign top_idx = CNT_W'(fit(len_sel_i) - SEL_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_cnt_q   <= '0;
            run_len_q   <= SEL_W'(MAX_W);
            first_bit_q <= 1'b0;
        end else begin
            run_cnt_q <= busy_o ? run_cnt_q + SEL_W'(1) : '0;
            if (!busy_o && en_i) begin
                run_len_q   <= fit(len_sel_i);
                first_bit_q <= par_i[top_idx];
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> (!busy_o && !ser_o)); // R1
    AST_START_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni) (!busy_o && en_i) |=> busy_o); // R2
    AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_o |-> (run_cnt_q < run_len_q)); // R3
    AST_EXACT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> (run_cnt_q == run_len_q)); // R3
    AST_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(busy_o) |-> (ser_o == first_bit_q)); // R4
    AST_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> (int'(run_cnt_q) >= MIN_W && int'(run_cnt_q) <= MAX_W)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_o |-> !ser_o); // R10

endmodule

bind burst_serializer bser_checker #(
    .MIN_W(MIN_W),
    .MAX_W(MAX_W),
    .SEL_W(SEL_W)
) i_bser_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .par_i    (par_i),
    .len_sel_i(len_sel_i),
    .ser_o    (ser_o),
    .busy_o   (busy_o)
);

// File: tb/test_burst_serializer.sv
`timescale 1ns/1ps
module test_burst_serializer;

    localparam real CLK_NS = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] par = '0;
    logic [4:0]  len_sel = 5'd8;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic        busy;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 1'b0;
    bit model_q[$];

    always #(CLK_NS / 2.0) clk = ~clk;

    burst_serializer i_burst_serializer (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .en_i     (en),
        .par_i    (par),
        .len_sel_i(len_sel),
        .ser_i    (ser_in),
        .ser_o    (ser_out),
        .busy_o   (busy)
    );

    function automatic int clampn(input int s);
        if (s < 6) return 6;
        if (s > 16) return 16;
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: a queue of the bits still to be sent.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_q.delete();
        end else if (model_q.size() == 0) begin
            if (en) begin
                for (int i = clampn(int'(len_sel)) - 1; i >= 0; i--) model_q.push_back(par[i]);
            end
        end else begin
            void'(model_q.pop_front());
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            automatic bit exp_busy = (model_q.size() > 0);
            automatic bit exp_ser  = exp_busy ? model_q[0] : 1'b0;
            chk(busy == exp_busy, "R3 busy per cycle", int'(busy), int'(exp_busy));
            chk(ser_out == exp_ser, exp_busy ? "R4 serial bit" : "R10 idle output",
                int'(ser_out), int'(exp_ser));
        end
    end

    // One burst: start it, optionally disturb inputs, collect bits and length.
    task automatic burst(input logic [15:0] w, input int sel, input bit hold_en,
                         input bit scramble, input string tag);
        int n = clampn(sel);
        int cnt = 0;
        logic [15:0] got = '0;
        logic [15:0] want;
        @(posedge clk); #1;
        par = w; len_sel = 5'(sel); en = 1'b1;
        @(posedge clk); #1;
        en = hold_en;
        if (scramble) begin
            par = ~w;
            len_sel = 5'(sel) ^ 5'h0b;
        end
        forever begin
            @(negedge clk);
            if (!busy) break;
            cnt++;
            got = {got[14:0], ser_out};
            if (scramble) ser_in = 1'($urandom);
        end
        en = 1'b0;
        want = w & 16'((32'h1 << n) - 1);
        chk(cnt == n, {tag, " R3 length"}, cnt, n);
        chk(got == want, {tag, " R4 word"}, int'(got), int'(want));
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int gap;
        en = 1'b1;
        par = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(ser_out == 1'b0, "R1 ser in reset", int'(ser_out), 0);
        en = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

        burst(16'hA5C3, 16, 1'b0, 1'b0, "R2");
        burst(16'h0035, 6, 1'b0, 1'b0, "R4");
        burst(16'hFFC0 | 16'h0012, 6, 1'b0, 1'b0, "R5");
        burst(16'hF0F0 | 16'h0155, 9, 1'b1, 1'b0, "R3 hold");
        burst(16'h1234, 12, 1'b0, 1'b1, "R6");
        burst(16'h5A5A, 11, 1'b0, 1'b1, "R9");
        burst(16'h002D, 0, 1'b0, 1'b0, "R7 low");
        burst(16'h0013, 3, 1'b0, 1'b0, "R7 below");
        burst(16'hBEEF, 20, 1'b0, 1'b0, "R7 high");
        burst(16'h7E81, 31, 1'b1, 1'b1, "R7 top");

        // R8: enable held high across the end of a burst.
        @(posedge clk); #1;
        par = 16'h0029; len_sel = 5'd6; en = 1'b1;
        @(negedge clk);
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
        gap = 0;
        while (!busy && gap < 10) begin
            gap++;
            @(negedge clk);
        end
        chk(gap == 1, "R8 idle gap", gap, 1);
        en = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);

        // R1: asynchronous reset in the middle of a burst.
        @(posedge clk); #1;
        par = 16'hFFFF; len_sel = 5'd16; en = 1'b1;
        @(posedge clk); #1;
        en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        cmp_on = 1'b0;
        rst_n = 1'b0;
        #1;
        chk(busy == 1'b0, "R1 async busy clear", int'(busy), 0);
        chk(ser_out == 1'b0, "R1 async ser clear", int'(ser_out), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 no burst after reset", int'(busy), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule